// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers four shared, level-sensitive PCI interrupt lines onto sixteen legacy interrupt-controller inputs. Each line has a byte-wide steering register. A value below sixteen names the output the line drives. Any larger value parks the line so that it drives nothing. The four registers sit together in one 32-bit word of a small configuration space. Software updates them through a port with byte enables and reads them back unchanged.

The block keeps a 64-bit contribution map, one bit per (output, line) pair at position output×4+line. Each output is the OR of its four map bits. When a line's level changes, only that line's bit under its current target is updated. Any write that touches a steering byte discards the map and rebuilds it from the live levels under the new steering. The outputs are registered and follow the cause by one clock. Two combinational helpers complete the block. One reports the steering state of a selected line. The other folds a device/function byte and an INTx pin onto a shared line index.

Top module: `irq_steer_top`

## Requirements
- R1: After a synchronous reset every steering byte reads 0x80, every output is low, and cfg_rdata is zero.
- R2: A write to dword index 0x18 (byte offset 0x60) stores wdata byte b into the steering register of line b for each set cfg_be[b]. Bytes whose enable is clear are kept. A read of that dword returns line b's byte in bits 8b+7..8b, one clock after cfg_re.
- R3: Writes to any other dword index change nothing. Reads of any other dword return zero.
- R4: A line whose steering value is 16 or more drives no output, whatever its level. Value 16 is the first disabled value.
- R5: When a steered line's level changes, the output it targets follows in the next clock.
- R6: Each output is the OR of all lines steered to it. It stays high while any of them is high.
- R7: A write to the steering dword with a nonzero byte enable rebuilds all outputs from the current line levels under the new steering, visible one clock later.
- R8: When a steering write and a line level change fall in the same cycle, the result reflects the new level under the new steering.
- R9: swz_line equals (swz_pin + swz_devfn[7:3] − 1) mod 4, combinationally.
- R10: For the line chosen by q_line, q_enabled is 1 exactly when its steering value is below 16. q_target then gives the low four bits of that value.
- R11: A write to the steering dword with cfg_be = 0 changes neither the registers nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables, one per steering byte |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| line_lvl | input | 4 | Shared PCI interrupt levels, active high |
| irq_out | output | 16 | Registered interrupt-controller input levels |
| q_line | input | 2 | Line selected for the steering query |
| q_enabled | output | 1 | Selected line is steered to an output |
| q_target | output | 4 | Output number of the selected line |
| swz_devfn | input | 8 | Device/function byte for the swizzle helper |
| swz_pin | input | 2 | INTx pin, 0 = A |
| swz_line | output | 2 | Shared line index produced by the swizzle |

## Verification
A steering write and a level change on a line can fall in the same clock. This is the collision between the rebuild path and the incremental update path. The bench provokes it by moving a line that is currently high to a new output with a single-byte write. In the same cycle it drops that line's level. The result is correct only if no output is left high: neither the old target from the incremental path nor the new one from a rebuild that used stale levels. Further vectors change the level and the steering of different lines together, and the outputs are compared with maps worked out by hand.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int BYTE_W    = 8;
  localparam int DEVFN_W   = 8;
  localparam int DEV_LSB   = 3;
  typedef logic [BYTE_W-1:0] steer_byte_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_steer_pkg::*;
#(
  parameter int          LINES   = 4,
  parameter int          ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] BASE_DW = 6'h18,
  parameter steer_byte_t RST_VAL = 8'h80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_re,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [LINES-1:0]         cfg_be,
  input  logic [LINES*BYTE_W-1:0]  cfg_wdata,
  output logic [LINES*BYTE_W-1:0]  cfg_rdata,
  output logic [LINES*BYTE_W-1:0]  steer_q,
  output logic [LINES*BYTE_W-1:0]  steer_nxt,
  output logic                     rebuild
);
  logic [LINES-1:0][BYTE_W-1:0] regs_q;
  logic [LINES-1:0][BYTE_W-1:0] regs_d;
  logic hit;

  assign hit     = (cfg_addr == BASE_DW);
  assign rebuild = cfg_we && hit && (|cfg_be);

  always_comb begin
    regs_d = regs_q;
    for (int l = 0; l < LINES; l++) begin
      if (cfg_we && hit && cfg_be[l])
        regs_d[l] = cfg_wdata[l*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LINES; l++) regs_q[l] <= RST_VAL;
      cfg_rdata <= '0;
    end else begin
      regs_q <= regs_d;
      if (cfg_re) cfg_rdata <= hit ? regs_q : '0;
    end
  end

  assign steer_q   = regs_q;
  assign steer_nxt = regs_d;
endmodule

// File: rtl/irq_contrib_map.sv
module irq_contrib_map
  import irq_steer_pkg::*;
#(
  parameter int LINES = 4,
  parameter int OUTS  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LINES*BYTE_W-1:0]  steer_q,
  input  logic [LINES*BYTE_W-1:0]  steer_nxt,
  input  logic                     rebuild,
  input  logic [LINES-1:0]         line_lvl,
  output logic [OUTS-1:0]          irq_out
);
  localparam int OUT_W = $clog2(OUTS);
  localparam int MAP_W = OUTS * LINES;

  logic [MAP_W-1:0] map_q, map_d;
  logic [LINES-1:0] lvl_q;
  logic [OUTS-1:0]  irq_d;

  function automatic logic steer_ok(input steer_byte_t v);
    return int'(v) < OUTS;
  endfunction

  function automatic int map_idx(input steer_byte_t v, input int line);
    return int'(v[OUT_W-1:0]) * LINES + line;
  endfunction

  always_comb begin
    map_d = map_q;
    if (rebuild) begin
      map_d = '0;
      for (int p = 0; p < LINES; p++) begin
        if (steer_ok(steer_nxt[p*BYTE_W +: BYTE_W]) && line_lvl[p])
          map_d[map_idx(steer_nxt[p*BYTE_W +: BYTE_W], p)] = 1'b1;
      end
    end else begin
      for (int p = 0; p < LINES; p++) begin
        if ((line_lvl[p] != lvl_q[p]) && steer_ok(steer_q[p*BYTE_W +: BYTE_W]))
          map_d[map_idx(steer_q[p*BYTE_W +: BYTE_W], p)] = line_lvl[p];
      end
    end
  end

  for (genvar n = 0; n < OUTS; n++) begin : g_or
    assign irq_d[n] = |map_d[n*LINES +: LINES];
  end

  always_ff @(posedge clk) begin
    lvl_q <= line_lvl;
    if (rst) begin
      map_q   <= '0;
      irq_out <= '0;
    end else begin
      map_q   <= map_d;
      irq_out <= irq_d;
    end
  end
endmodule

// File: rtl/irq_slot_swizzle.sv
module irq_slot_swizzle
  import irq_steer_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LW   = $clog2(LINES),
  localparam int DN_W = DEVFN_W - DEV_LSB
) (
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [LW-1:0]      pin,
  output logic [LW-1:0]      line
);
  logic [DN_W-1:0] sum;
  assign sum  = DN_W'(pin) + devfn[DEVFN_W-1:DEV_LSB] - DN_W'(1);
  assign line = LW'(sum);
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int          LINES   = 4,
  parameter int          OUTS    = 16,
  parameter int          ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] BASE_DW = 6'h18,
  parameter steer_byte_t RST_VAL = 8'h80,
  localparam int LW    = $clog2(LINES),
  localparam int OUT_W = $clog2(OUTS),
  localparam int DW    = LINES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [LINES-1:0]   cfg_be,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  input  logic [LINES-1:0]   line_lvl,
  output logic [OUTS-1:0]    irq_out,
  input  logic [LW-1:0]      q_line,
  output logic               q_enabled,
  output logic [OUT_W-1:0]   q_target,
  input  logic [DEVFN_W-1:0] swz_devfn,
  input  logic [LW-1:0]      swz_pin,
  output logic [LW-1:0]      swz_line
);
  logic [DW-1:0] steer_q, steer_nxt;
  logic          rebuild;
  steer_byte_t   q_byte;

  irq_route_regs #(
    .LINES(LINES), .ADDR_W(ADDR_W), .BASE_DW(BASE_DW), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .steer_q(steer_q), .steer_nxt(steer_nxt),
    .rebuild(rebuild)
  );

  irq_contrib_map #(.LINES(LINES), .OUTS(OUTS)) u_map (
    .clk(clk), .rst(rst), .steer_q(steer_q), .steer_nxt(steer_nxt),
    .rebuild(rebuild), .line_lvl(line_lvl), .irq_out(irq_out)
  );

  irq_slot_swizzle #(.LINES(LINES)) u_swz (
    .devfn(swz_devfn), .pin(swz_pin), .line(swz_line)
  );

  assign q_byte    = steer_q[int'(q_line)*BYTE_W +: BYTE_W];
  assign q_enabled = int'(q_byte) < OUTS;
  assign q_target  = q_byte[OUT_W-1:0];
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int LINES  = 4,
  parameter int OUTS   = 16,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] BASE_DW = 6'h18
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic                cfg_re,
  input logic [ADDR_W-1:0]   cfg_addr,
  input logic [LINES-1:0]    cfg_be,
  input logic [LINES*8-1:0]  cfg_wdata,
  input logic [LINES*8-1:0]  cfg_rdata,
  input logic [LINES-1:0]    line_lvl,
  input logic [OUTS-1:0]     irq_out,
  input logic [LINES*8-1:0]  steer_flat
);
  localparam int OUT_W = $clog2(OUTS);
  logic any_ok;

  always_comb begin
    any_ok = 1'b0;
    for (int p = 0; p < LINES; p++)
      if (int'(steer_flat[p*8 +: 8]) < OUTS) any_ok = 1'b1;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> irq_out == '0);

  // R4
  all_parked_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_ok && !cfg_we) |=> irq_out == '0);

  // R11
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && $stable(line_lvl)) |=> $stable(irq_out));

  // R7
  move_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == BASE_DW && cfg_be == LINES'(1) &&
     int'(cfg_wdata[7:0]) < OUTS && line_lvl[0])
    |=> irq_out[$past(cfg_wdata[OUT_W-1:0])]);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && cfg_addr == BASE_DW) |=> cfg_rdata == $past(steer_flat));

  // R3
  other_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && cfg_addr != BASE_DW) |=> cfg_rdata == '0);
endmodule

bind irq_steer_top irq_steer_chk #(
  .LINES(LINES), .OUTS(OUTS), .ADDR_W(ADDR_W), .BASE_DW(BASE_DW)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
  .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .line_lvl(line_lvl), .irq_out(irq_out),
  .steer_flat(steer_q)
);

// File: tb/irq_steer_top_tb_top.sv
module irq_steer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [5:0]  cfg_addr = 6'h18;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  line_lvl = 4'h0;
  logic [15:0] irq_out;
  logic [1:0]  q_line = 2'd0;
  logic        q_enabled;
  logic [3:0]  q_target;
  logic [7:0]  swz_devfn = 8'h0;
  logic [1:0]  swz_pin = 2'd0;
  logic [1:0]  swz_line;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_steer_top dut_i (.*);

  // {be, wdata, levels, expected irq_out}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {4'hF, 32'h8080_0503, 4'b0000, 16'h0000},  // R2 R4
    {4'h0, 32'h0000_0000, 4'b0001, 16'h0008},  // R5
    {4'h0, 32'h0000_0000, 4'b0011, 16'h0028},  // R5
    {4'h0, 32'h0000_0000, 4'b1111, 16'h0028},  // R4
    {4'h4, 32'h0003_0000, 4'b1111, 16'h0028},  // R7
    {4'h0, 32'h0000_0000, 4'b1110, 16'h0028},  // R6
    {4'h0, 32'h0000_0000, 4'b1010, 16'h0020},  // R6
    {4'h8, 32'h0F00_0000, 4'b1010, 16'h8020},  // R7
    {4'h2, 32'h0000_0A00, 4'b0000, 16'h0000},  // R8
    {4'h0, 32'h0000_0000, 4'b0010, 16'h0400},  // R5
    {4'h0, 32'hFFFF_FFFF, 4'b0010, 16'h0400},  // R11 (we with be=0)
    {4'h2, 32'h0000_1000, 4'b0010, 16'h0000},  // R4 value 16
    {4'h2, 32'h0000_0F00, 4'b0010, 16'h8000}   // R7 value 15
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs", 32'(irq_out), 32'h0);
    check("R1 rdata", cfg_rdata, 32'h0);
    cfg_read(6'h18, rd);
    check("R1 steer reset", rd, 32'h8080_8080);

    for (int i = 0; i < NV; i++) begin
      cfg_be    = VEC[i][55:52];
      cfg_wdata = VEC[i][51:20];
      line_lvl  = VEC[i][19:16];
      cfg_addr  = 6'h18;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; cfg_be = 4'h0;
      check($sformatf("vector %0d R2-R8,R11", i), 32'(irq_out), 32'(VEC[i][15:0]));
    end
    // steering now: line0=3, line1=15, line2=3, line3=15; levels 0010
    cfg_read(6'h18, rd);
    check("R2 readback", rd, 32'h0F03_0F03);
    cfg_read(6'h19, rd);
    check("R3 other read", rd, 32'h0);
    cfg_write(6'h19, 4'hF, 32'h0000_0000);
    check("R3 other write outputs", 32'(irq_out), 32'h8000);
    cfg_read(6'h18, rd);
    check("R3 other write regs", rd, 32'h0F03_0F03);

    // R8 collision: line1 high on 15 moved to 7 while it drops
    cfg_we = 1'b1; cfg_addr = 6'h18; cfg_be = 4'h2; cfg_wdata = 32'h0000_0700;
    line_lvl = 4'b0000;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0;
    check("R8 move and drop", 32'(irq_out), 32'h0);
    line_lvl = 4'b0010;
    @(negedge clk);
    check("R5 new target", 32'(irq_out), 32'h0080);

    // R10 query
    q_line = 2'd0; #1;
    check("R10 line0 en", {31'h0, q_enabled}, 32'h1);
    check("R10 line0 tgt", {28'h0, q_target}, 32'h3);
    cfg_write(6'h18, 4'h8, 32'h8000_0000);
    q_line = 2'd3; #1;
    check("R10 line3 off", {31'h0, q_enabled}, 32'h0);
    check("R11 unrelated rebuild keeps", 32'(irq_out), 32'h0080);

    // R9 swizzle
    swz_devfn = 8'h08; swz_pin = 2'd0; #1;
    check("R9 dev1 pinA", 32'(swz_line), 32'd0);
    swz_devfn = 8'h10; swz_pin = 2'd3; #1;
    check("R9 dev2 pinD", 32'(swz_line), 32'd0);
    swz_devfn = 8'h00; swz_pin = 2'd0; #1;
    check("R9 dev0 pinA", 32'(swz_line), 32'd3);
    swz_devfn = 8'hFF; swz_pin = 2'd1; #1;
    check("R9 dev31 pinB", 32'(swz_line), 32'd3);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears", 32'(irq_out), 32'h0);
    cfg_read(6'h18, rd);
    check("R1 reset regs", rd, 32'h8080_8080);
    summary();
  end
endmodule